// File: doc/BRIEF.md
# Load-Dependent Switching Frequency Selector

This block picks the switching rate for a current-mode buck controller. Light load shows up as the inductor current falling to zero once per switching cycle. The block counts those zero-current events on consecutive cycles. After a fixed number of them it raises a low-load flag, and the switching clock drops to half the base rate, which cuts switching loss. A high-load indication from an analog comparator cancels the low-load state at once and returns the converter to the base rate.

All analog parts sit outside the block: the zero-current detector, the high-load comparator, the oscillator ramp and slope compensation. Their outputs arrive as asynchronous digital levels and are synchronized inside. The switching clock comes from the fast reference clock through a period counter. Once the flag is set, the event counter is parked in reset so that it stops toggling.

Top module: `freq_mode_sel`

## Requirements
- R1: While `en` is high, the block starts with `low_load` = 0 and `sw_clk` at the base period of BASE_PERIOD reference cycles (200 by default).
- R2: Each rising edge of `zc_det` counts as exactly one event, whether the pulse lasts a few reference cycles or many.
- R3: The flag `low_load` rises within a few reference cycles of the EVT_TARGET-th event (8 by default), provided `hi_load` stays low and no count-clearing gap occurs between the events.
- R4: While `low_load` = 1, further `zc_det` pulses have no effect. After the flag is cleared, a full EVT_TARGET fresh events are needed to set it again.
- R5: While `hi_load` is high, the event count is held at zero and `zc_det` pulses are not counted.
- R6: When `hi_load` rises while `low_load` = 1, `low_load` falls within three reference cycles.
- R7: `sw_clk` has a 50 % duty cycle. Its period is BASE_PERIOD reference cycles while the flag is clear and 2*BASE_PERIOD while it is set.
- R8: A rate change takes effect only at the end of a switching period, so every high phase of `sw_clk` lasts exactly BASE_PERIOD/2 or BASE_PERIOD reference cycles.
- R9: If `hi_load` and the final counted event arrive in the same cycle, `hi_load` wins and `low_load` stays 0.
- R10: Driving `en` low clears `low_load`, `sw_clk` and the event count asynchronously, without waiting for a clock edge.
- R11: A complete switching period that contains no `zc_det` edge resets the event count to zero, so the events must be consecutive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| en | input | 1 | Active-high enable; low acts as an asynchronous clear |
| zc_det | input | 1 | Asynchronous pulse from the zero-current detector |
| hi_load | input | 1 | Asynchronous level from the high-load comparator |
| low_load | output | 1 | High while low-frequency mode is selected |
| sw_clk | output | 1 | Switching clock, at the base rate or at half of it |

## Verification
The checker assumes that `zc_det` and `hi_load` are stable for at least one reference cycle at a time, so that every edge survives the two-flop synchronizer. It also assumes that `en` is the only reset. The bench drives both inputs at falling clock edges. Its `zc_det` pulses are at least three cycles wide and arrive well inside one switching period of each other, except where a deliberate long gap tests the consecutive-event rule. The tie case is made by raising both inputs on the same falling edge, so that both cross the equal-depth synchronizers together.

// File: rtl/fms_pkg.sv
package fms_pkg;

   typedef enum logic {
      MODE_FAST = 1'b0,
      MODE_SLOW = 1'b1
   } fms_mode_e;

   localparam int unsigned FMS_MIN_SYNC = 2;

endpackage

// File: rtl/fms_sync.sv
module fms_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          RISE_DET = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic din,
   output logic sync_out
);
   import fms_pkg::*;

   if (STAGES < FMS_MIN_SYNC) begin : g_bad_stages
      $error("fms_sync: STAGES must be at least %0d", FMS_MIN_SYNC);
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], din};
   end

   if (RISE_DET) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) prev_q <= 1'b0;
         else         prev_q <= chain_q[STAGES-1];
      end
      assign sync_out = chain_q[STAGES-1] & ~prev_q;
   end else begin : g_level
      assign sync_out = chain_q[STAGES-1];
   end

endmodule

// File: rtl/fms_evt_counter.sv
module fms_evt_counter #(
   parameter int unsigned EVT_TARGET = 8,
   localparam int unsigned CW = $clog2(EVT_TARGET)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          zc_rise,
   input  logic          hi_lvl,
   input  logic          period_end,
   output logic          low_flag,
   output logic [CW-1:0] evt_cnt
);

   if (EVT_TARGET < 2) begin : g_bad_target
      $error("fms_evt_counter: EVT_TARGET must be at least 2");
   end

   localparam logic [CW-1:0] LAST = CW'(EVT_TARGET - 1);

   logic          flag_q;
   logic          seen_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
         seen_q <= 1'b0;
      end else if (hi_lvl) begin
         // high load overrides everything, including a same-cycle final event
         cnt_q  <= '0;
         flag_q <= 1'b0;
         seen_q <= 1'b0;
      end else if (flag_q) begin
         // decision made: counter parked
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (zc_rise) begin
            if (cnt_q == LAST) begin
               cnt_q  <= '0;
               flag_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (period_end && !seen_q) begin
            cnt_q <= '0;
         end
         if (period_end) seen_q <= zc_rise;
         else if (zc_rise) seen_q <= 1'b1;
      end
   end

   assign low_flag = flag_q;
   assign evt_cnt  = cnt_q;

endmodule

// File: rtl/fms_clkgen.sv
module fms_clkgen #(
   parameter int unsigned BASE_PERIOD = 200,
   localparam int unsigned PW = $clog2(2 * BASE_PERIOD)
) (
   input  logic clk,
   input  logic arst_n,
   input  logic slow_req,
   output logic sw_clk,
   output logic period_end
);
   import fms_pkg::*;

   if ((BASE_PERIOD < 4) || (BASE_PERIOD % 2 != 0)) begin : g_bad_period
      $error("fms_clkgen: BASE_PERIOD must be even and at least 4");
   end

   localparam logic [PW-1:0] LIM_FAST  = PW'(BASE_PERIOD - 1);
   localparam logic [PW-1:0] LIM_SLOW  = PW'(2 * BASE_PERIOD - 1);
   localparam logic [PW-1:0] HALF_FAST = PW'(BASE_PERIOD / 2);
   localparam logic [PW-1:0] HALF_SLOW = PW'(BASE_PERIOD);

   fms_mode_e     mode_q;
   logic [PW-1:0] phase_q;
   logic [PW-1:0] limit;
   logic [PW-1:0] half;
   logic          clk_q;

   always_comb begin
      limit = (mode_q == MODE_SLOW) ? LIM_SLOW  : LIM_FAST;
      half  = (mode_q == MODE_SLOW) ? HALF_SLOW : HALF_FAST;
   end

   assign period_end = (phase_q == limit);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         phase_q <= '0;
         mode_q  <= MODE_FAST;
         clk_q   <= 1'b0;
      end else begin
         clk_q <= (phase_q < half);
         if (period_end) begin
            phase_q <= '0;
            mode_q  <= slow_req ? MODE_SLOW : MODE_FAST;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

   assign sw_clk = clk_q;

endmodule

// File: rtl/freq_mode_sel.sv
module freq_mode_sel #(
   parameter int unsigned BASE_PERIOD = 200,
   parameter int unsigned EVT_TARGET  = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_ref,
   input  logic en,
   input  logic zc_det,
   input  logic hi_load,
   output logic low_load,
   output logic sw_clk
);
   localparam int unsigned CW = $clog2(EVT_TARGET);

   logic          zc_rise;
   logic          hi_lvl;
   logic          period_end;
   logic [CW-1:0] evt_cnt;

   fms_sync #(.STAGES(SYNC_STAGES), .RISE_DET(1'b1)) u_zc_sync (
      .clk      (clk_ref),
      .arst_n   (en),
      .din      (zc_det),
      .sync_out (zc_rise)
   );

   fms_sync #(.STAGES(SYNC_STAGES), .RISE_DET(1'b0)) u_hi_sync (
      .clk      (clk_ref),
      .arst_n   (en),
      .din      (hi_load),
      .sync_out (hi_lvl)
   );

   fms_evt_counter #(.EVT_TARGET(EVT_TARGET)) u_cnt (
      .clk        (clk_ref),
      .arst_n     (en),
      .zc_rise    (zc_rise),
      .hi_lvl     (hi_lvl),
      .period_end (period_end),
      .low_flag   (low_load),
      .evt_cnt    (evt_cnt)
   );

   fms_clkgen #(.BASE_PERIOD(BASE_PERIOD)) u_clk (
      .clk        (clk_ref),
      .arst_n     (en),
      .slow_req   (low_load),
      .sw_clk     (sw_clk),
      .period_end (period_end)
   );

endmodule

// File: rtl/fms_checker.sv
module fms_checker #(
   parameter int unsigned BASE_PERIOD = 200,
   parameter int unsigned EVT_TARGET  = 8,
   localparam int unsigned CW = $clog2(EVT_TARGET),
   localparam int unsigned RW = $clog2(2 * BASE_PERIOD + 2)
) (
   input logic          clk,
   input logic          en,
   input logic          zc_rise,
   input logic          hi_sync,
   input logic [CW-1:0] evt_cnt,
   input logic          low_load,
   input logic          sw_clk
);

   logic [RW-1:0] hi_run;

   always_ff @(posedge clk or negedge en) begin
      if (!en)         hi_run <= '0;
      else if (sw_clk) hi_run <= hi_run + 1'b1;
      else             hi_run <= '0;
   end

   // R10: disabled block holds outputs clear
   a_r10_async_clear: assert property (@(posedge clk)
      !en |-> (!low_load && !sw_clk));

   // R3: final event with no override sets the flag
   a_r3_set_on_target: assert property (@(posedge clk) disable iff (!en)
      (zc_rise && !hi_sync && !low_load && evt_cnt == CW'(EVT_TARGET - 1)) |=> low_load);

   // R4: counter parked while flag set
   a_r4_parked: assert property (@(posedge clk) disable iff (!en)
      low_load |-> (evt_cnt == '0));

   // R5, R6, R9: high load clears count and flag next cycle
   a_r5_hi_clears: assert property (@(posedge clk) disable iff (!en)
      hi_sync |=> (evt_cnt == '0 && !low_load));

   // R8: every high phase is a whole half period
   a_r8_no_runt: assert property (@(posedge clk) disable iff (!en)
      $fell(sw_clk) |-> (hi_run == RW'(BASE_PERIOD / 2) || hi_run == RW'(BASE_PERIOD)));

endmodule

bind freq_mode_sel fms_checker #(
   .BASE_PERIOD (BASE_PERIOD),
   .EVT_TARGET  (EVT_TARGET)
) u_chk (
   .clk      (clk_ref),
   .en       (en),
   .zc_rise  (zc_rise),
   .hi_sync  (hi_lvl),
   .evt_cnt  (evt_cnt),
   .low_load (low_load),
   .sw_clk   (sw_clk)
);

// File: tb/freq_mode_sel_tb.sv
`timescale 1ns/1ps
module freq_mode_sel_tb;

   localparam int BASE = 200;

   logic clk_ref = 1'b0;
   logic en      = 1'b0;
   logic zc_det  = 1'b0;
   logic hi_load = 1'b0;
   wire  low_load;
   wire  sw_clk;

   always #2.5 clk_ref = ~clk_ref;

   freq_mode_sel #(.BASE_PERIOD(BASE), .EVT_TARGET(8), .SYNC_STAGES(2)) u_dut (
      .clk_ref  (clk_ref),
      .en       (en),
      .zc_det   (zc_det),
      .hi_load  (hi_load),
      .low_load (low_load),
      .sw_clk   (sw_clk)
   );

   typedef struct {
      string req;
      int    exp;
   } exp_t;

   exp_t sb_q[$];
   int   obs;
   event obs_ev;
   int   n_vec = 0;
   int   n_bad = 0;

   // monitor: pops expectations and compares them with observations
   initial begin
      exp_t e;
      forever begin
         @(obs_ev);
         if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d expected none", obs);
         end else begin
            e = sb_q.pop_front();
            n_vec++;
            if (obs !== e.exp) begin
               n_bad++;
               $display("FAIL %s: actual %0d expected %0d", e.req, obs, e.exp);
            end
         end
      end
   end

   task automatic expect_val(input string req, input int exp, input int act);
      sb_q.push_back('{req, exp});
      obs = act;
      -> obs_ev;
      #0.1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_ref);
   endtask

   task automatic pulse_zc(input int n, input int width);
      for (int i = 0; i < n; i++) begin
         @(negedge clk_ref); zc_det = 1'b1;
         idle(width);
         zc_det = 1'b0;
         idle(37);
      end
   endtask

   task automatic measure(output int per, output int hi);
      logic prev;
      prev = sw_clk;
      do begin
         prev = sw_clk;
         @(negedge clk_ref);
      end while (!(prev == 1'b0 && sw_clk == 1'b1));
      per = 0;
      hi  = 0;
      do begin
         if (sw_clk) hi++;
         per++;
         prev = sw_clk;
         @(negedge clk_ref);
      end while (!(prev == 1'b0 && sw_clk == 1'b1));
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int per, hi;
      idle(4);
      expect_val("R10 flag while disabled", 0, int'(low_load));
      en = 1'b1;
      idle(5);
      expect_val("R1 flag after enable", 0, int'(low_load));
      measure(per, hi);
      expect_val("R1 base period", BASE, per);
      expect_val("R7 base duty", BASE / 2, hi);

      // R2: one long pulse plus six short ones give seven events
      pulse_zc(1, 30);
      pulse_zc(6, 3);
      idle(5);
      expect_val("R2 seven edges no flag", 0, int'(low_load));
      pulse_zc(1, 3);
      expect_val("R3 eighth edge sets flag", 1, int'(low_load));

      // R4: extra pulses ignored while set
      pulse_zc(10, 3);
      expect_val("R4 flag held", 1, int'(low_load));
      idle(3 * BASE);
      measure(per, hi);
      expect_val("R7 slow period", 2 * BASE, per);
      expect_val("R8 slow high phase", BASE, hi);

      // R6: high load clears at once
      @(negedge clk_ref); hi_load = 1'b1;
      idle(4);
      expect_val("R6 flag cleared by high load", 0, int'(low_load));
      pulse_zc(10, 3);
      expect_val("R5 pulses during high load", 0, int'(low_load));
      hi_load = 1'b0;
      idle(4 * BASE);
      measure(per, hi);
      expect_val("R7 back to base period", BASE, per);
      expect_val("R8 base high phase", BASE / 2, hi);
      pulse_zc(7, 3);
      expect_val("R4 fresh count needed", 0, int'(low_load));
      pulse_zc(1, 3);
      expect_val("R3 set again", 1, int'(low_load));

      // R9: tie between final event and high load
      @(negedge clk_ref); hi_load = 1'b1;
      idle(5);
      hi_load = 1'b0;
      idle(5);
      pulse_zc(7, 3);
      @(negedge clk_ref); zc_det = 1'b1; hi_load = 1'b1;
      idle(10);
      expect_val("R9 high load wins tie", 0, int'(low_load));
      zc_det = 1'b0; hi_load = 1'b0;
      idle(10);
      expect_val("R9 flag stays clear", 0, int'(low_load));

      // R11: a period without events restarts the count
      idle(3 * BASE);
      pulse_zc(5, 3);
      idle(3 * BASE);
      pulse_zc(7, 3);
      expect_val("R11 gap restarts count", 0, int'(low_load));
      pulse_zc(1, 3);
      expect_val("R11 eight after gap", 1, int'(low_load));

      // R10: asynchronous clear
      @(negedge clk_ref); en = 1'b0;
      #1;
      expect_val("R10 flag cleared async", 0, int'(low_load));
      expect_val("R10 clock cleared async", 0, int'(sw_clk));
      idle(3);
      en = 1'b1;
      measure(per, hi);
      expect_val("R1 base period after re-enable", BASE, per);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule